// File: doc/BRIEF.md
# Vector Register Execution Unit

This block is the datapath of a vector coprocessor. It keeps a file of vector registers and runs one element-wise vector instruction at a time. A single instruction sweeps every element of a register through a short pipeline, one element per clock, so a whole loop of scalar work becomes one command. Arithmetic comes in a vector-vector form and in vector-scalar forms that apply one scalar operand to every element. Elements are plain integers.

An instruction arrives on a valid/ready handshake. It carries an opcode, a destination register number, two source register numbers, a scalar operand and a memory base address. Loads and stores move one word per cycle over a simple memory port whose read data returns one cycle after the read strobe. A one-cycle `done` pulse marks the end of each instruction, and the unit takes a new instruction from that same cycle on.

Top module: `vec_exec_unit`

## Requirements
- R1: While reset is held and on the first cycle after its release, `in_ready` is 1 and `done`, `mem_re` and `mem_we` are 0.
- R2: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` stays 0 until the cycle in which `done` is 1. Any `in_valid` seen while `in_ready` is 0 has no effect.
- R3: Opcode 0 (load) asserts `mem_re` once per cycle for element i = 0 up to NELEM-1 in ascending order, with `mem_addr` = base + 8*i. The word on `mem_rdata` in the following cycle becomes element i of the destination register.
- R4: Opcode 1 (store) asserts `mem_we` once per cycle for element i = 0 up to NELEM-1 in ascending order, with `mem_addr` = base + 8*i and `mem_wdata` = element i of source register 1. A load and a store never happen in the same cycle.
- R5: Opcode 2 (vector add) writes, for every i, source1[i] + source2[i] modulo 2^W into destination[i].
- R6: Opcode 3 (vector-scalar add) writes, for every i, source1[i] + scalar modulo 2^W into destination[i].
- R7: Opcode 4 (vector-scalar multiply) writes, for every i, the low W bits of source1[i] * scalar into destination[i].
- R8: `done` is 1 for exactly one cycle. It rises NELEM+1 clock edges after the accepting edge, and `in_ready` is 1 in that cycle.
- R9: The result is still correct when the destination register is also one or both of the sources.
- R10: Opcodes 5, 6 and 7 are accepted and complete with the same `done` timing. They change no register and make no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction can be taken |
| in_op | input | 3 | Opcode |
| in_vd | input | $clog2(NREGS) | Destination register number |
| in_vs1 | input | $clog2(NREGS) | First source register number (store source) |
| in_vs2 | input | $clog2(NREGS) | Second source register number |
| in_scalar | input | W | Scalar operand |
| in_base | input | AW | Memory base address for load or store |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address in bytes |
| mem_wdata | output | W | Store data |
| mem_rdata | input | W | Read data, valid the cycle after `mem_re` |
| done | output | 1 | One-cycle pulse at instruction end |

## Verification
A wrong element index or a stale pipeline valid shows up at once at the memory port. The address would skip or repeat instead of stepping by 8, or `done` would come early or late against the NELEM+1 edge count. A corrupted register or a wrong operand mux stays hidden inside the file until a later store brings it out. For that reason every arithmetic instruction in the bench is followed by a store of its destination, and the store's words are compared against a model. A fault therefore appears within one instruction of its cause. Instructions offered while the unit is busy target the live destination, so wrongly accepting one would corrupt a result that is checked right afterwards.

// File: rtl/vec_exec_unit.sv
module vec_exec_unit #(
  parameter int NREGS = 32,
  parameter int NELEM = 64,
  parameter int W     = 64,
  parameter int AW    = 32,
  localparam int RW   = $clog2(NREGS),
  localparam int EW   = $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [RW-1:0] in_vd,
  input  logic [RW-1:0] in_vs1,
  input  logic [RW-1:0] in_vs2,
  input  logic [W-1:0]  in_scalar,
  input  logic [AW-1:0] in_base,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          done
);
  localparam logic [2:0]    OP_LD   = 3'd0;
  localparam logic [2:0]    OP_ST   = 3'd1;
  localparam logic [2:0]    OP_VADD = 3'd2;
  localparam logic [2:0]    OP_ADDS = 3'd3;
  localparam logic [2:0]    OP_MULS = 3'd4;
  localparam logic [EW-1:0] LAST    = EW'(NELEM - 1);

  logic [W-1:0]  rf [NREGS][NELEM];
  logic          busy, iss, s2_v;
  logic [EW-1:0] idx, s2_idx;
  logic [2:0]    op_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [W-1:0]  sc_q, a_q, b_q, result;
  logic [AW-1:0] base_q;

  wire accept = in_valid && !busy;
  wire writes = (op_q == OP_LD) || (op_q == OP_VADD) || (op_q == OP_ADDS) || (op_q == OP_MULS);
  wire [EW-1:0] aidx = (op_q == OP_ST) ? s2_idx : idx;

  assign in_ready  = !busy;
  assign mem_re    = iss && (op_q == OP_LD);
  assign mem_we    = s2_v && (op_q == OP_ST);
  assign mem_addr  = base_q + (AW'(aidx) << 3);
  assign mem_wdata = a_q;

  always_comb begin
    case (op_q)
      OP_LD:   result = mem_rdata;
      OP_MULS: result = a_q * b_q;
      default: result = a_q + b_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      iss    <= 1'b0;
      s2_v   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      s2_idx <= '0;
      op_q   <= '0;
      vd_q   <= '0;
      vs1_q  <= '0;
      vs2_q  <= '0;
      sc_q   <= '0;
      base_q <= '0;
    end else begin
      done <= 1'b0;
      s2_v <= iss;
      if (iss) begin
        s2_idx <= idx;
        if (idx == LAST) iss <= 1'b0;
        else             idx <= idx + 1'b1;
      end
      if (accept) begin
        busy   <= 1'b1;
        iss    <= 1'b1;
        idx    <= '0;
        op_q   <= in_op;
        vd_q   <= in_vd;
        vs1_q  <= in_vs1;
        vs2_q  <= in_vs2;
        sc_q   <= in_scalar;
        base_q <= in_base;
      end
      if (s2_v && s2_idx == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (iss) begin
      a_q <= rf[vs1_q][idx];
      b_q <= (op_q == OP_VADD) ? rf[vs2_q][idx] : sc_q;
    end
    if (s2_v && writes) rf[vd_q][s2_idx] <= result;
  end
endmodule

// File: rtl/vec_exec_unit_chk.sv
module vec_exec_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !mem_we);

  assert_mem_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> !in_ready);

  assert_load_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> mem_addr == $past(mem_addr) + AW'(8));

  assert_store_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + AW'(8));
endmodule

bind vec_exec_unit vec_exec_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/test_vec_exec_unit.sv
`timescale 1ns/1ps
module test_vec_exec_unit;
  localparam int NR = 4, NE = 8, W = 16, AW = 12;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic in_ready, mem_re, mem_we, done;
  logic [2:0] in_op = '0;
  logic [1:0] in_vd = '0, in_vs1 = '0, in_vs2 = '0;
  logic [W-1:0] in_scalar = '0, mem_wdata, mem_rdata = '0;
  logic [AW-1:0] in_base = '0, mem_addr;

  vec_exec_unit #(.NREGS(NR), .NELEM(NE), .W(W), .AW(AW)) i_vec_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_vd(in_vd), .in_vs1(in_vs1), .in_vs2(in_vs2),
    .in_scalar(in_scalar), .in_base(in_base), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done));

  always #4 clk = ~clk;

  logic [W-1:0] mem [512];
  logic [W-1:0] mdl [NR][NE];
  int checks = 0, fails = 0, acc_cnt = 0, wd = 0;
  logic [AW-1:0] cur_base = '0;

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[11:3]];
    if (mem_we) mem[mem_addr[11:3]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (mem_re || mem_we)) begin
      chk(mem_addr == cur_base + AW'(8 * acc_cnt), mem_re ? "R3 addr" : "R4 addr",
          int'(mem_addr), int'(cur_base + AW'(8 * acc_cnt)));
      acc_cnt++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [2:0] op, input int vd, input int vs1, input int vs2,
                     input logic [W-1:0] sc, input logic [AW-1:0] base);
    int cyc;
    bit seen, rdy_ok;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 idle ready", int'(in_ready), 1);
    in_op = op; in_vd = 2'(vd); in_vs1 = 2'(vs1); in_vs2 = 2'(vs2);
    in_scalar = sc; in_base = base; in_valid = 1'b1;
    cur_base = base; acc_cnt = 0;
    @(negedge clk);
    // R2: offer a corrupting add to the live destination while busy
    in_op = 3'd3; in_scalar = 16'h1111; in_vs1 = 2'(vd);
    cyc = 0; seen = 0; rdy_ok = 1;
    while (cyc < 4 * NE) begin
      if (done) begin seen = 1; break; end
      if (in_ready) rdy_ok = 0;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    chk(rdy_ok, "R2 ready low while busy", 0, 0);
    chk(seen && cyc == NE + 1, "R8 done timing", cyc, NE + 1);
    chk(in_ready == 1'b1, "R8 ready with done", int'(in_ready), 1);
    chk(acc_cnt == ((op <= 3'd1) ? NE : 0), (op > 3'd4) ? "R10 no access" : "R3 R4 access count",
        acc_cnt, (op <= 3'd1) ? NE : 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single", int'(done), 0);
  endtask

  task automatic load(input int r, input logic [AW-1:0] base);
    run(3'd0, r, 0, 0, '0, base);
    for (int i = 0; i < NE; i++) mdl[r][i] = mem[base[11:3] + 9'(i)];
  endtask

  task automatic dump(input int r, input string req);
    logic [AW-1:0] base;
    base = AW'(12'h800 + 64 * r);
    run(3'd1, 0, r, 0, '0, base);
    for (int i = 0; i < NE; i++)
      chk(mem[base[11:3] + 9'(i)] == mdl[r][i], req, int'(mem[base[11:3] + 9'(i)]), int'(mdl[r][i]));
  endtask

  task automatic arith(input logic [2:0] op, input int vd, input int vs1, input int vs2,
                       input logic [W-1:0] sc, input string req);
    run(op, vd, vs1, vs2, sc, '0);
    for (int i = 0; i < NE; i++) begin
      case (op)
        3'd2:    mdl[vd][i] = mdl[vs1][i] + mdl[vs2][i];
        3'd3:    mdl[vd][i] = mdl[vs1][i] + sc;
        default: mdl[vd][i] = W'(mdl[vs1][i] * sc);
      endcase
    end
    dump(vd, req);
  endtask

  logic [W-1:0] scs [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h00FF, 16'h1234};

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = W'(i * 40503 + 12345);
    repeat (2) @(negedge clk);
    chk(in_ready == 1 && done == 0 && mem_re == 0 && mem_we == 0, "R1 in reset",
        {in_ready, done, mem_re, mem_we}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1 && done == 0 && mem_re == 0 && mem_we == 0, "R1 after reset",
        {in_ready, done, mem_re, mem_we}, 4'b1000);

    for (int r = 0; r < NR; r++) load(r, AW'(8 * (r * NE + 3 * r)));
    for (int r = 0; r < NR; r++) dump(r, "R3 R4 load store");

    for (int s = 0; s < 6; s++) begin
      for (int r = 0; r < NR; r++) load(r, AW'(8 * (s * 40 + r * 9 + 1)));
      for (int k = 0; k < NR; k++) begin
        arith(3'd2, k, (k + 1) % NR, (k + 2) % NR, scs[s], "R5 vadd");
        arith(3'd3, (k + 1) % NR, (k + 2) % NR, 0, scs[s], "R6 vadds");
        arith(3'd4, (k + 2) % NR, (k + 3) % NR, 0, scs[s], "R7 vmuls");
      end
      arith(3'd2, s % NR, s % NR, s % NR, scs[s], "R9 in-place vadd");
      arith(3'd3, (s + 1) % NR, (s + 1) % NR, 0, scs[s], "R9 in-place vadds");
      arith(3'd4, (s + 2) % NR, (s + 2) % NR, 0, scs[s], "R9 in-place vmuls");
    end

    for (int op = 5; op < 8; op++) begin
      run(3'(op), op % NR, (op + 1) % NR, 0, 16'h0F0F, AW'(8));
      for (int r = 0; r < NR; r++) dump(r, "R10 reserved opcode");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule